// File: doc/BRIEF.md
# Thread-Block Admission Controller

This block decides whether a newly launched group of cooperating threads may be placed on one multiprocessor. Each request gives the group's thread count and the number of registers that each of its threads needs. The controller tests three limits together: free residency slots, the resident-thread budget and the register pool. If all three fit, it grants the request, returns the residency slot it reserved and charges the group's resources. If any limit fails, it refuses the request and changes nothing.

When a resident group finishes, a release naming its slot returns exactly the threads and registers that were charged to that slot. Those registers stay reserved for that slot until it is released. A release and a request in the same cycle are handled together: the release is credited first and the request is tested against the result. A release that names an empty slot has no effect and raises a one-cycle error pulse.

Top module: `blk_admit_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every usage counter is zero, and grant, refuse and rel_err are low.
- R2: A request in cycle t gives a one-cycle grant pulse in cycle t+1 when every limit fits. grant_slot then holds the lowest-numbered slot that is free after any release in cycle t, and the counters in cycle t+1 include the new group.
- R3: A request is refused if the resident threads plus its thread count would exceed MAX_THREADS (768). A sum exactly equal to the limit fits.
- R4: A request costs req_threads × req_regs registers. It is refused if the registers in use plus this cost would exceed REG_POOL (8192). A cost that exactly fills the pool fits.
- R5: At most SLOTS (8) groups are resident. A request made while every slot is occupied is refused.
- R6: A request whose thread count is 0 or larger than MAX_BLK_THREADS (512) is refused.
- R7: A refused request leaves used_slots, used_threads and used_regs unchanged.
- R8: A release of an occupied slot in cycle t removes that slot's thread count and register cost from the counters seen in cycle t+1, and frees the slot for later grants.
- R9: When a release and a request arrive in the same cycle, the release is credited before the request is tested, and the freed slot may be granted at once.
- R10: A release naming an unoccupied slot leaves all counters unchanged and gives a one-cycle rel_err pulse in the next cycle.
- R11: Every request gives exactly one of grant or refuse in the next cycle, and neither is raised in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Admission request this cycle |
| req_threads | input | BTW (10) | Thread count of the requesting group |
| req_regs | input | RPTW (8) | Registers needed per thread |
| rel_valid | input | 1 | Release request this cycle |
| rel_slot | input | SW (3) | Slot being released |
| grant | output | 1 | Request of the previous cycle admitted |
| refuse | output | 1 | Request of the previous cycle refused |
| grant_slot | output | SW (3) | Slot reserved by the last grant |
| used_slots | output | SCW (4) | Occupied slots |
| used_threads | output | TW (10) | Resident threads |
| used_regs | output | RW (14) | Registers reserved |
| rel_err | output | 1 | Previous release named an empty slot |

## Verification
The bench builds the controller with its default limits: eight slots, 768 threads, an 8192-entry register pool and 512 threads per group. These sizes let short sequences reach every limit. Three groups of 256 threads exactly fill the thread budget. Two groups of 256 threads at 11 registers each leave too little room for a third, which exercises the register limit while the thread limit still fits. One group of 512 threads at 16 registers exactly fills the pool, and eight single-thread groups fill every slot while the other budgets are nearly empty.

// File: rtl/blk_admit_pkg.sv
// Package: shared types for the admission controller.
// Assumes: nothing beyond IEEE 1800-2017.
package blk_admit_pkg;

    // Outcome of one cycle's admission decision
    typedef enum logic [1:0] {
        VERDICT_IDLE   = 2'd0,
        VERDICT_GRANT  = 2'd1,
        VERDICT_REFUSE = 2'd2
    } verdict_e;

endpackage

// File: rtl/bac_free_pick.sv
// Module: lowest-index free slot finder.
// Takes an occupancy mask and returns the smallest index whose bit is clear,
// plus a flag that says whether any slot is free.
// Assumes: N >= 1 and SW wide enough to hold N-1.
module bac_free_pick #(
    parameter int N  = 8,
    parameter int SW = 3
) (
    input  logic [N-1:0]  occ,
    output logic [SW-1:0] idx,
    output logic          any_free
);
    // Scan from the top down so the lowest free index is the one that remains
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occ[i]) idx = SW'(i);
        end
    end

    // At least one slot is clear
    assign any_free = ~&occ;
endmodule

// File: rtl/bac_budget_check.sv
// Module: combinational admission test.
// Works out a request's register cost and tests its thread count against the
// allowed range. It also tests the slot count, thread budget and register pool
// against usage that already includes any same-cycle release.
// Assumes: the credited inputs never exceed their limits.
module bac_budget_check #(
    parameter int SLOTS           = 8,
    parameter int MAX_THREADS     = 768,
    parameter int REG_POOL        = 8192,
    parameter int MAX_BLK_THREADS = 512,
    parameter int TW              = 10,
    parameter int BTW             = 10,
    parameter int RPTW            = 8,
    parameter int RW              = 14,
    parameter int SCW             = 4
) (
    input  logic [SCW-1:0]      cred_slots,
    input  logic [TW-1:0]       cred_thr,
    input  logic [RW-1:0]       cred_reg,
    input  logic [BTW-1:0]      req_thr,
    input  logic [RPTW-1:0]     req_rpt,
    output logic [BTW+RPTW-1:0] cost,
    output logic                fits
);
    localparam int CW   = BTW + RPTW;
    localparam int TSW  = ((TW > BTW) ? TW : BTW) + 1;
    localparam int RSW  = ((CW > RW) ? CW : RW) + 1;

    logic [TSW-1:0] thr_sum;
    logic [RSW-1:0] reg_sum;
    logic           size_ok, slot_ok, thr_ok, reg_ok;

    // Register charge is threads times registers per thread
    always_comb cost = CW'(req_thr) * CW'(req_rpt);

    // Budget sums after this request would be admitted
    always_comb begin
        thr_sum = TSW'(cred_thr) + TSW'(req_thr);
        reg_sum = RSW'(cred_reg) + RSW'(cost);
    end

    // Each limit tested on its own, then combined
    always_comb begin
        size_ok = (req_thr != '0) && (TSW'(req_thr) <= TSW'(MAX_BLK_THREADS));
        slot_ok = (cred_slots < SCW'(SLOTS));
        thr_ok  = (thr_sum <= TSW'(MAX_THREADS));
        reg_ok  = (reg_sum <= RSW'(REG_POOL));
        fits    = size_ok && slot_ok && thr_ok && reg_ok;
    end
endmodule

// File: rtl/bac_slot_table.sv
// Module: per-slot record of resident groups.
// Each slot holds an occupied bit, the thread count and the register cost that
// were charged. If a slot is released and reallocated in the same cycle, the
// allocation wins. A release reads the charged amounts back combinationally.
// Assumes: SLOTS is a power of two, so every index value names a real slot.
module bac_slot_table #(
    parameter int SLOTS = 8,
    parameter int SW    = 3,
    parameter int BTW   = 10,
    parameter int RW    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [SW-1:0]    alloc_idx,
    input  logic [BTW-1:0]   alloc_thr,
    input  logic [RW-1:0]    alloc_cost,
    input  logic             free_en,
    input  logic [SW-1:0]    free_idx,
    output logic [SLOTS-1:0] occ,
    output logic [BTW-1:0]   free_thr,
    output logic [RW-1:0]    free_cost
);
    logic [BTW-1:0] thr_q  [SLOTS];
    logic [RW-1:0]  cost_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Hold the occupancy and charge of one slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[g]    <= 1'b0;
                thr_q[g]  <= '0;
                cost_q[g] <= '0;
            end else if (alloc_en && alloc_idx == SW'(g)) begin
                occ[g]    <= 1'b1;
                thr_q[g]  <= alloc_thr;
                cost_q[g] <= alloc_cost;
            end else if (free_en && free_idx == SW'(g)) begin
                occ[g]    <= 1'b0;
            end
        end
    end

    // Charged amounts of the slot being released
    assign free_thr  = thr_q[free_idx];
    assign free_cost = cost_q[free_idx];

    // R2: the picker only hands out a slot that is free after this cycle's release
    a_r2_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !(free_en && free_idx == alloc_idx)) |-> !occ[alloc_idx]);
endmodule

// File: rtl/blk_admit_ctrl.sv
// Module: thread-block admission controller (top).
// Admits a group of threads to one multiprocessor only if a slot, the thread
// budget and the register pool all fit, and keeps the running totals. A
// same-cycle release is credited before the request is tested. A release of an
// empty slot is dropped and flagged. All outputs are registered, so the
// results appear one cycle after the inputs.
// Assumes: SLOTS is a power of two.
module blk_admit_ctrl #(
    parameter int SLOTS           = 8,
    parameter int MAX_THREADS     = 768,
    parameter int REG_POOL        = 8192,
    parameter int MAX_BLK_THREADS = 512,
    parameter int RPTW            = 8,
    parameter int TW              = $clog2(MAX_THREADS + 1),
    parameter int BTW             = $clog2(MAX_BLK_THREADS + 1),
    parameter int RW              = $clog2(REG_POOL + 1),
    parameter int SW              = $clog2(SLOTS),
    parameter int SCW             = $clog2(SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [BTW-1:0]  req_threads,
    input  logic [RPTW-1:0] req_regs,
    input  logic            rel_valid,
    input  logic [SW-1:0]   rel_slot,
    output logic            grant,
    output logic            refuse,
    output logic [SW-1:0]   grant_slot,
    output logic [SCW-1:0]  used_slots,
    output logic [TW-1:0]   used_threads,
    output logic [RW-1:0]   used_regs,
    output logic            rel_err
);
    import blk_admit_pkg::*;

    localparam int CW = BTW + RPTW;

    logic [SLOTS-1:0] occ, occ_avail;
    logic [BTW-1:0]   rel_thr;
    logic [RW-1:0]    rel_cost;
    logic             rel_hit;
    logic [SCW-1:0]   cred_slots;
    logic [TW-1:0]    cred_thr;
    logic [RW-1:0]    cred_reg;
    logic [SW-1:0]    pick_idx;
    logic             pick_any;
    logic [CW-1:0]    cost;
    logic             fits;
    verdict_e         verdict;

    // Release is honoured only for an occupied slot
    assign rel_hit = rel_valid && occ[rel_slot];

    // Usage after crediting this cycle's release
    always_comb begin
        cred_thr   = used_threads - (rel_hit ? TW'(rel_thr) : '0);
        cred_reg   = used_regs - (rel_hit ? rel_cost : '0);
        cred_slots = used_slots - SCW'(rel_hit);
        occ_avail  = occ & ~(rel_hit ? (SLOTS'(1) << rel_slot) : '0);
    end

    bac_free_pick #(.N(SLOTS), .SW(SW)) u_pick (
        .occ      (occ_avail),
        .idx      (pick_idx),
        .any_free (pick_any)
    );

    bac_budget_check #(
        .SLOTS(SLOTS), .MAX_THREADS(MAX_THREADS), .REG_POOL(REG_POOL),
        .MAX_BLK_THREADS(MAX_BLK_THREADS), .TW(TW), .BTW(BTW),
        .RPTW(RPTW), .RW(RW), .SCW(SCW)
    ) u_budget (
        .cred_slots (cred_slots),
        .cred_thr   (cred_thr),
        .cred_reg   (cred_reg),
        .req_thr    (req_threads),
        .req_rpt    (req_regs),
        .cost       (cost),
        .fits       (fits)
    );

    // Decide this cycle's outcome
    always_comb begin
        if (!req_valid)             verdict = VERDICT_IDLE;
        else if (fits && pick_any)  verdict = VERDICT_GRANT;
        else                        verdict = VERDICT_REFUSE;
    end

    bac_slot_table #(.SLOTS(SLOTS), .SW(SW), .BTW(BTW), .RW(RW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (verdict == VERDICT_GRANT),
        .alloc_idx  (pick_idx),
        .alloc_thr  (req_threads),
        .alloc_cost (RW'(cost)),
        .free_en    (rel_hit),
        .free_idx   (rel_slot),
        .occ        (occ),
        .free_thr   (rel_thr),
        .free_cost  (rel_cost)
    );

    // Commit counters and register the decision flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_slots   <= '0;
            used_threads <= '0;
            used_regs    <= '0;
            grant        <= 1'b0;
            refuse       <= 1'b0;
            grant_slot   <= '0;
            rel_err      <= 1'b0;
        end else begin
            grant   <= (verdict == VERDICT_GRANT);
            refuse  <= (verdict == VERDICT_REFUSE);
            rel_err <= rel_valid && !occ[rel_slot];
            if (verdict == VERDICT_GRANT) begin
                used_slots   <= cred_slots + SCW'(1);
                used_threads <= cred_thr + TW'(req_threads);
                used_regs    <= cred_reg + RW'(cost);
                grant_slot   <= pick_idx;
            end else begin
                used_slots   <= cred_slots;
                used_threads <= cred_thr;
                used_regs    <= cred_reg;
            end
        end
    end

    // R3: resident threads never exceed the budget
    a_r3_thread_cap: assert property (@(posedge clk) disable iff (!rst_n)
        used_threads <= TW'(MAX_THREADS));

    // R4: reserved registers never exceed the pool
    a_r4_reg_cap: assert property (@(posedge clk) disable iff (!rst_n)
        used_regs <= RW'(REG_POOL));

    // R5: occupied slots never exceed the slot count
    a_r5_slot_cap: assert property (@(posedge clk) disable iff (!rst_n)
        used_slots <= SCW'(SLOTS));

    // R7: a refusal with no release alongside leaves all counters as they were
    a_r7_refuse_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (refuse && $past(!rel_valid)) |->
        ($stable(used_slots) && $stable(used_threads) && $stable(used_regs)));

    // R10: a release error only follows a release and changes no slot count alone
    a_r10_err_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> $past(rel_valid));
    a_r10_err_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_err && !grant) |-> $stable(used_slots));

    // R11: exactly one outcome, and only after a request
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && refuse));
    a_r11_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || refuse) |-> $past(req_valid));
endmodule

// File: tb/blk_admit_ctrl_bench.sv
`timescale 1ns/1ps
module blk_admit_ctrl_bench;

    typedef struct packed {
        logic        rq;
        logic [9:0]  thr;
        logic [7:0]  rpt;
        logic        rl;
        logic [2:0]  rs;
        logic        eg;
        logic        er;
        logic [2:0]  es;
        logic [9:0]  eth;
        logic [13:0] ereg;
        logic [3:0]  esl;
        logic        eerr;
    } vec_t;

    // Each row: request, release, then the outputs expected one cycle later
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1,10'd256,8'd10,1'b0,3'd0, 1'b1,1'b0,3'd0,10'd256,14'd2560,4'd1,1'b0}, // R2 slot0
        '{1'b1,10'd256,8'd10,1'b0,3'd0, 1'b1,1'b0,3'd1,10'd512,14'd5120,4'd2,1'b0}, // R2 slot1
        '{1'b1,10'd256,8'd10,1'b0,3'd0, 1'b1,1'b0,3'd2,10'd768,14'd7680,4'd3,1'b0}, // R3 exact fit
        '{1'b1,10'd1,  8'd1, 1'b0,3'd0, 1'b0,1'b1,3'd0,10'd768,14'd7680,4'd3,1'b0}, // R3 R7 over
        '{1'b0,10'd0,  8'd0, 1'b1,3'd1, 1'b0,1'b0,3'd0,10'd512,14'd5120,4'd2,1'b0}, // R8 release
        '{1'b0,10'd0,  8'd0, 1'b1,3'd1, 1'b0,1'b0,3'd0,10'd512,14'd5120,4'd2,1'b1}, // R10 empty
        '{1'b1,10'd256,8'd11,1'b0,3'd0, 1'b1,1'b0,3'd1,10'd768,14'd7936,4'd3,1'b0}, // R2 reuse 1
        '{1'b1,10'd256,8'd1, 1'b1,3'd0, 1'b1,1'b0,3'd0,10'd768,14'd5632,4'd3,1'b0}, // R9 same cycle
        '{1'b0,10'd0,  8'd0, 1'b1,3'd2, 1'b0,1'b0,3'd0,10'd512,14'd3072,4'd2,1'b0}, // R8
        '{1'b0,10'd0,  8'd0, 1'b1,3'd0, 1'b0,1'b0,3'd0,10'd256,14'd2816,4'd1,1'b0}, // R8
        '{1'b1,10'd256,8'd11,1'b0,3'd0, 1'b1,1'b0,3'd0,10'd512,14'd5632,4'd2,1'b0}, // R4 fits
        '{1'b1,10'd256,8'd11,1'b0,3'd0, 1'b0,1'b1,3'd0,10'd512,14'd5632,4'd2,1'b0}, // R4 R7 pool
        '{1'b1,10'd0,  8'd4, 1'b0,3'd0, 1'b0,1'b1,3'd0,10'd512,14'd5632,4'd2,1'b0}, // R6 zero
        '{1'b0,10'd0,  8'd0, 1'b0,3'd0, 1'b0,1'b0,3'd0,10'd512,14'd5632,4'd2,1'b0}  // R11 idle
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_threads = '0;
    logic [7:0] req_regs = '0;
    logic       rel_valid = 1'b0;
    logic [2:0] rel_slot = '0;
    logic       grant, refuse, rel_err;
    logic [2:0] grant_slot;
    logic [3:0] used_slots;
    logic [9:0] used_threads;
    logic [13:0] used_regs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    blk_admit_ctrl u_blk_admit_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_threads(req_threads), .req_regs(req_regs),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .grant(grant), .refuse(refuse), .grant_slot(grant_slot),
        .used_slots(used_slots), .used_threads(used_threads),
        .used_regs(used_regs), .rel_err(rel_err)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic eg, input logic er,
                             input logic [2:0] es, input int eth, input int ereg,
                             input int esl, input logic eerr);
        cmp(tag, "grant", int'(grant), int'(eg));
        cmp(tag, "refuse", int'(refuse), int'(er));
        if (eg) cmp(tag, "grant_slot", int'(grant_slot), int'(es));
        cmp(tag, "used_threads", int'(used_threads), eth);
        cmp(tag, "used_regs", int'(used_regs), ereg);
        cmp(tag, "used_slots", int'(used_slots), esl);
        cmp(tag, "rel_err", int'(rel_err), int'(eerr));
    endtask

    // Drive one cycle of stimulus at a falling edge; outputs settle after the next rise
    task automatic step(input logic rq, input int thr, input int rpt,
                        input logic rl, input int rs);
        req_valid   = rq;
        req_threads = 10'(thr);
        req_regs    = 8'(rpt);
        rel_valid   = rl;
        rel_slot    = 3'(rs);
        @(negedge clk);
        req_valid = 1'b0;
        rel_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        rel_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check_out("R1 reset", 1'b0, 1'b0, 3'd0, 0, 0, 0, 1'b0);

        // Table walk over budgets, releases and same-cycle handling
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].rq, int'(VECS[i].thr), int'(VECS[i].rpt),
                 VECS[i].rl, int'(VECS[i].rs));
            check_out($sformatf("R2 R3 R4 R6 R7 R8 R9 R10 R11 vec%0d", i),
                      VECS[i].eg, VECS[i].er, VECS[i].es, int'(VECS[i].eth),
                      int'(VECS[i].ereg), int'(VECS[i].esl), VECS[i].eerr);
        end

        // R1: reset clears all usage mid-run
        do_reset();
        @(negedge clk);
        check_out("R1 re-reset", 1'b0, 1'b0, 3'd0, 0, 0, 0, 1'b0);

        // R6: oversize group refused on an empty processor
        step(1'b1, 513, 1, 1'b0, 0);
        check_out("R6 oversize", 1'b0, 1'b1, 3'd0, 0, 0, 0, 1'b0);

        // R4: a cost that exactly fills the pool fits, then one more register does not
        step(1'b1, 512, 16, 1'b0, 0);
        check_out("R4 exact pool", 1'b1, 1'b0, 3'd0, 512, 8192, 1, 1'b0);
        step(1'b1, 1, 1, 1'b0, 0);
        check_out("R4 pool full", 1'b0, 1'b1, 3'd0, 512, 8192, 1, 1'b0);

        // R5: eight small groups occupy slots 0..7 in order, the ninth is refused
        do_reset();
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1, 1, 1'b0, 0);
            check_out("R5 R2 fill", 1'b1, 1'b0, 3'(k), k + 1, k + 1, k + 1, 1'b0);
        end
        step(1'b1, 1, 1, 1'b0, 0);
        check_out("R5 slots full", 1'b0, 1'b1, 3'd0, 8, 8, 8, 1'b0);

        // R9: release slot 5 with a request in the same cycle, slot 5 is reused
        step(1'b1, 2, 3, 1'b1, 5);
        check_out("R9 reuse", 1'b1, 1'b0, 3'd5, 9, 13, 8, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule